// File: doc/BRIEF.md
# SPI Register Access Frontend

This block is an SPI slave that lets a host reach the registers and data queues of a serial-port peripheral. The host talks in 16-bit words. Each word names a register and either writes a byte to it or reads a byte back. The read byte comes back in the same word, during the last eight clocks. Words can follow one another without a gap while chip select stays low. Each word is decoded and carried out as soon as its sixteenth bit arrives.

Address 0 is the data port. A read of address 0, which is the all-zero word, takes one byte from the receive queue. A write to address 0 puts one byte into the transmit queue. Two more addresses are served inside the block:
- the receive-queue fill count;
- a fixed revision code that the host checks to identify the device.

Every other address goes out on a register strobe interface to the peripheral's register file. The SPI pins are sampled by the block clock, so each half period of SCLK must last at least four block-clock cycles.

Top module: `spi_regfe`

## Requirements
- R1: After reset, `spi_miso` is 0 and none of `reg_wr`, `reg_rd`, `txq_push` or `rxq_pop` is asserted.
- R2: The interface uses SPI mode 0: SCLK idles low, both sides sample on the rising edge, and the block changes MISO on the falling edge. A word is 16 bits sent MSB first. Bit 15 is the write flag (1 = write), bits 14:8 are the address, and bits 7:0 are the data. SCLK high and low phases each last at least 4 clk cycles.
- R3: For a read word, the block shifts out zeros in bits 15:8 of the same slot and the read byte in bits 7:0. For a general register, the read byte is `reg_rdata`, sampled while `reg_addr` holds that word's address, after the eighth bit.
- R4: A write word to a general address gives a one-cycle `reg_wr` pulse after the 16th bit. During the pulse `reg_addr` holds the address and `reg_wdata` holds the data byte.
- R5: A read word to a general address gives a one-cycle `reg_rd` pulse once the word completes.
- R6: A write word to address 0 gives a one-cycle `txq_push` pulse with the data byte on `txq_data`, and no `reg_wr`.
- R7: The all-zero word returns `rxq_data`, the head of the receive queue, and pulses `rxq_pop` once when the word completes.
- R8: When `rxq_level` is 0, the all-zero word returns 0x00 and gives no `rxq_pop`.
- R9: A read of address 0x12 returns `rxq_level` and gives no `reg_rd`.
- R10: A read of address 0x1F returns the revision code 0xA5. Write words to 0x12 or 0x1F are dropped, with no strobe.
- R11: Any number of words may run back to back in one chip-select window. Each is carried out in order, and reads return data written by earlier words in the same window.
- R12: Raising chip select in the middle of a word discards that word with no strobe. The next word after chip select falls again is aligned from its first bit.
- R13: Each complete word gives at most one strobe among `reg_wr`, `reg_rd`, `txq_push` and `rxq_pop`, and no strobe occurs except at word completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 7 | Address of the current word |
| reg_wdata | output | 8 | Write data for the register file |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe (for read side effects) |
| reg_rdata | input | 8 | Register file value at `reg_addr` |
| txq_push | output | 1 | Transmit queue push strobe |
| txq_data | output | 8 | Byte to push into the transmit queue |
| rxq_pop | output | 1 | Receive queue pop strobe |
| rxq_data | input | 8 | Head byte of the receive queue |
| rxq_level | input | 8 | Receive queue fill count |

## Verification
If the bit counter or the captured header goes wrong, the low byte that comes back is shifted by one bit or belongs to the wrong register. The host sees this within the same word it is reading. A decode fault shows up once the word completes, as a missing, doubled or misdirected strobe: a queue byte lost or duplicated, or a write landing in the register file when it should have gone to the transmit queue. If an aborted word is not discarded, the next word after chip select falls again shows it: that word's write goes to the wrong address, or its read returns data from a stale slot.

// File: rtl/spi_regfe_pkg.sv
package spi_regfe_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int HDR_W  = 1 + ADDR_W;
    localparam int WORD_W = HDR_W + DATA_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int DBIT_W = $clog2(DATA_W);
    localparam int LVL_W  = 8;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef enum logic [2:0] {
        ACC_REG_RD,
        ACC_REG_WR,
        ACC_POP,
        ACC_PUSH,
        ACC_LEVEL,
        ACC_REV,
        ACC_DROP
    } acc_e;

    function automatic acc_e classify(hdr_t h,
                                      logic [ADDR_W-1:0] port_a,
                                      logic [ADDR_W-1:0] lvl_a,
                                      logic [ADDR_W-1:0] rev_a);
        acc_e k;
        if (h.wr) begin
            if (h.addr == port_a)                          k = ACC_PUSH;
            else if (h.addr == lvl_a || h.addr == rev_a)   k = ACC_DROP;
            else                                           k = ACC_REG_WR;
        end else begin
            if (h.addr == port_a)      k = ACC_POP;
            else if (h.addr == lvl_a)  k = ACC_LEVEL;
            else if (h.addr == rev_a)  k = ACC_REV;
            else                       k = ACC_REG_RD;
        end
        return k;
    endfunction

endpackage

// File: rtl/spi_regfe_sync.sv
module spi_regfe_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regfe_shift.sv
module spi_regfe_shift
    import spi_regfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              hdr_valid,
    output hdr_t              hdr,
    output logic              word_done,
    output logic [DATA_W-1:0] word_data,
    output logic              miso
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_W);

    logic              sclk_d;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-2:0] shreg;
    logic              rise, fall;
    logic [CNT_W-1:0]  out_idx;

    assign rise    = !cs_n_s &&  sclk_s && !sclk_d;
    assign fall    = !cs_n_s && !sclk_s &&  sclk_d;
    assign out_idx = LAST_BIT - cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            hdr       <= '0;
            hdr_valid <= 1'b0;
            word_done <= 1'b0;
            word_data <= '0;
            miso      <= 1'b0;
        end else begin
            sclk_d    <= sclk_s;
            hdr_valid <= 1'b0;
            word_done <= 1'b0;
            if (cs_n_s) begin
                cnt  <= '0;
                miso <= 1'b0;
            end else begin
                if (rise) begin
                    shreg <= {shreg[WORD_W-3:0], mosi_s};
                    cnt   <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
                    if (cnt == HDR_LAST) begin
                        hdr       <= hdr_t'({shreg[HDR_W-2:0], mosi_s});
                        hdr_valid <= 1'b1;
                    end
                    if (cnt == LAST_BIT) begin
                        word_data <= {shreg[DATA_W-2:0], mosi_s};
                        word_done <= 1'b1;
                    end
                end
                if (fall) begin
                    miso <= (cnt >= HDR_CNT) ? rd_byte[out_idx[DBIT_W-1:0]] : 1'b0;
                end
            end
        end
    end

    // R12: chip select high leaves the slot empty and idle
    a_r12_cs_clears: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (cnt == '0 && !miso && !word_done));

endmodule

// File: rtl/spi_regfe_exec.sv
module spi_regfe_exec
    import spi_regfe_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 7'h00,
    parameter logic [ADDR_W-1:0] LVL_ADDR  = 7'h12,
    parameter logic [ADDR_W-1:0] REV_ADDR  = 7'h1F,
    parameter logic [DATA_W-1:0] REV_VALUE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  hdr_t              hdr,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] rxq_data,
    input  logic [LVL_W-1:0]  rxq_level,
    output logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              rxq_pop,
    output logic              txq_push,
    output logic [DATA_W-1:0] txq_data
);
    acc_e kind;
    logic cap_pend;
    logic rx_nonempty;

    assign kind        = classify(hdr, PORT_ADDR, LVL_ADDR, REV_ADDR);
    assign reg_addr    = hdr.addr;
    assign rx_nonempty = (rxq_level != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_pend  <= 1'b0;
            rd_byte   <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            rxq_pop   <= 1'b0;
            txq_push  <= 1'b0;
            txq_data  <= '0;
        end else begin
            cap_pend <= hdr_valid;
            reg_wr   <= 1'b0;
            reg_rd   <= 1'b0;
            rxq_pop  <= 1'b0;
            txq_push <= 1'b0;
            if (cap_pend) begin
                case (kind)
                    ACC_POP:    rd_byte <= rx_nonempty ? rxq_data : '0;
                    ACC_LEVEL:  rd_byte <= DATA_W'(rxq_level);
                    ACC_REV:    rd_byte <= REV_VALUE;
                    ACC_REG_RD: rd_byte <= reg_rdata;
                    default:    rd_byte <= '0;
                endcase
            end
            if (word_done) begin
                case (kind)
                    ACC_REG_WR: begin
                        reg_wr    <= 1'b1;
                        reg_wdata <= word_data;
                    end
                    ACC_REG_RD: reg_rd <= 1'b1;
                    ACC_PUSH: begin
                        txq_push <= 1'b1;
                        txq_data <= word_data;
                    end
                    ACC_POP:    rxq_pop <= rx_nonempty;
                    default:    ;
                endcase
            end
        end
    end

    // R13: at most one strobe per word
    a_r13_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_wr, reg_rd, rxq_pop, txq_push}));

    // R13: strobes only follow a completed word
    a_r13_strobe_after_word: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd || rxq_pop || txq_push) |-> $past(word_done));

    // R8: never pop an empty receive queue
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        rxq_pop |-> ($past(rxq_level) != '0));

    // R10: read-only addresses never reach the register file as writes
    a_r10_ro_no_write: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (reg_addr != LVL_ADDR && reg_addr != REV_ADDR));

endmodule

// File: rtl/spi_regfe.sv
module spi_regfe
    import spi_regfe_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] PORT_ADDR   = 7'h00,
    parameter logic [ADDR_W-1:0] LVL_ADDR    = 7'h12,
    parameter logic [ADDR_W-1:0] REV_ADDR    = 7'h1F,
    parameter logic [DATA_W-1:0] REV_VALUE   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              txq_push,
    output logic [DATA_W-1:0] txq_data,
    output logic              rxq_pop,
    input  logic [DATA_W-1:0] rxq_data,
    input  logic [LVL_W-1:0]  rxq_level
);
    logic [2:0]        pins_s;
    logic              hdr_valid, word_done;
    hdr_t              hdr;
    logic [DATA_W-1:0] word_data, rd_byte;

    spi_regfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   (pins_s)
    );

    spi_regfe_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .rd_byte   (rd_byte),
        .hdr_valid (hdr_valid),
        .hdr       (hdr),
        .word_done (word_done),
        .word_data (word_data),
        .miso      (spi_miso)
    );

    spi_regfe_exec #(
        .PORT_ADDR (PORT_ADDR),
        .LVL_ADDR  (LVL_ADDR),
        .REV_ADDR  (REV_ADDR),
        .REV_VALUE (REV_VALUE)
    ) u_exec (
        .clk       (clk),
        .rst       (rst),
        .hdr_valid (hdr_valid),
        .hdr       (hdr),
        .word_done (word_done),
        .word_data (word_data),
        .reg_rdata (reg_rdata),
        .rxq_data  (rxq_data),
        .rxq_level (rxq_level),
        .rd_byte   (rd_byte),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .rxq_pop   (rxq_pop),
        .txq_push  (txq_push),
        .txq_data  (txq_data)
    );
endmodule

// File: tb/spi_regfe_bench.sv
`timescale 1ns/1ps
module spi_regfe_bench;
    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, txq_data, rxq_data, rxq_level;
    logic       reg_wr, reg_rd, txq_push, rxq_pop;

    always #4 clk = ~clk;

    spi_regfe u_spi_regfe (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .txq_push(txq_push), .txq_data(txq_data),
        .rxq_pop(rxq_pop), .rxq_data(rxq_data), .rxq_level(rxq_level)
    );

    // peripheral model
    logic [7:0] regs [128];
    logic [7:0] rx_mem [16];
    logic [7:0] tx_log [16];
    logic [3:0] rx_head;
    logic [7:0] rx_cnt;
    int         n_wr, n_rd, n_pop, n_push;
    logic       load_en = 1'b0;
    logic [7:0] load_val = 8'h00;

    assign reg_rdata = regs[reg_addr];
    assign rxq_data  = rx_mem[rx_head];
    assign rxq_level = rx_cnt;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) regs[i] <= 8'h00;
            for (int i = 0; i < 16; i++) rx_mem[i] <= 8'h00;
            rx_head <= 4'd0; rx_cnt <= 8'd0;
            n_wr <= 0; n_rd <= 0; n_pop <= 0; n_push <= 0;
        end else begin
            if (reg_wr) begin regs[reg_addr] <= reg_wdata; n_wr <= n_wr + 1; end
            if (reg_rd) n_rd <= n_rd + 1;
            if (txq_push) begin tx_log[n_push[3:0]] <= txq_data; n_push <= n_push + 1; end
            if (load_en) begin
                rx_mem[rx_head + rx_cnt[3:0]] <= load_val;
                rx_cnt <= rx_cnt + 8'd1;
            end else if (rxq_pop) begin
                rx_head <= rx_head + 4'd1;
                rx_cnt  <= rx_cnt - 8'd1;
                n_pop   <= n_pop + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cs_low();
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HP) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3*HP) @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] w, output logic [15:0] r, input int nbits);
        r = 16'h0000;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) spi_mosi = w[15-i];
            repeat (HP-1) @(negedge clk);
            r[15-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HP) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic load_rx(input logic [7:0] v);
        @(negedge clk) begin load_en = 1'b1; load_val = v; end
        @(negedge clk) load_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 miso", int'(spi_miso), 0);
        chk("R1 strobes", int'({reg_wr, reg_rd, txq_push, rxq_pop}), 0);
    endtask

    task automatic t_revid();
        logic [15:0] r;
        int rd0 = n_rd;
        cs_low(); xfer(16'h1F00, r, 16); cs_high();
        chk("R10 revid", int'(r[7:0]), 'hA5);
        chk("R3 upper byte zero", int'(r[15:8]), 0);
        chk("R10 revid no reg_rd", n_rd, rd0);
    endtask

    task automatic t_wr_rd();
        logic [15:0] r;
        int wr0 = n_wr, rd0 = n_rd;
        cs_low(); xfer(16'h853C, r, 16); cs_high();
        chk("R4 reg_wr count", n_wr, wr0 + 1);
        chk("R2 R4 written byte", int'(regs[5]), 'h3C);
        cs_low(); xfer(16'h0500, r, 16); cs_high();
        chk("R3 readback", int'(r), 'h003C);
        chk("R5 reg_rd count", n_rd, rd0 + 1);
    endtask

    task automatic t_b2b();
        logic [15:0] r1, r2, r3, r4;
        cs_low();
        xfer(16'h8611, r1, 16); xfer(16'h8722, r2, 16);
        xfer(16'h0600, r3, 16); xfer(16'h0700, r4, 16);
        cs_high();
        chk("R11 first read", int'(r3[7:0]), 'h11);
        chk("R11 second read", int'(r4[7:0]), 'h22);
    endtask

    task automatic t_push();
        logic [15:0] r;
        int p0 = n_push, other0 = n_wr + n_rd + n_pop;
        cs_low(); xfer(16'h805A, r, 16); xfer(16'h80C3, r, 16); cs_high();
        chk("R6 push count", n_push, p0 + 2);
        chk("R6 first byte", int'(tx_log[p0[3:0]]), 'h5A);
        chk("R6 second byte", int'(tx_log[4'(p0 + 1)]), 'hC3);
        chk("R13 no other strobe", n_wr + n_rd + n_pop, other0);
    endtask

    task automatic t_pop();
        logic [15:0] ra, rb, rc, rd;
        int p0 = n_pop, rd0 = n_rd;
        load_rx(8'h41); load_rx(8'h42); load_rx(8'h43);
        cs_low();
        xfer(16'h1200, ra, 16); xfer(16'h0000, rb, 16);
        xfer(16'h0000, rc, 16); xfer(16'h1200, rd, 16);
        cs_high();
        chk("R9 level before", int'(ra[7:0]), 3);
        chk("R7 first pop", int'(rb[7:0]), 'h41);
        chk("R7 second pop", int'(rc[7:0]), 'h42);
        chk("R9 level after", int'(rd[7:0]), 1);
        chk("R7 pop count", n_pop, p0 + 2);
        chk("R9 no reg_rd", n_rd, rd0);
    endtask

    task automatic t_empty();
        logic [15:0] ra, rb, rc;
        int p0 = n_pop;
        cs_low();
        xfer(16'h0000, ra, 16); xfer(16'h0000, rb, 16); xfer(16'h1200, rc, 16);
        cs_high();
        chk("R7 last byte", int'(ra[7:0]), 'h43);
        chk("R8 empty returns zero", int'(rb), 0);
        chk("R8 one pop only", n_pop, p0 + 1);
        chk("R8 level zero", int'(rc[7:0]), 0);
    endtask

    task automatic t_ro();
        logic [15:0] r1, r2;
        int wr0 = n_wr, all0 = n_wr + n_rd + n_pop + n_push;
        cs_low();
        xfer(16'h9F77, r1, 16); xfer(16'h92FF, r1, 16);
        xfer(16'h1F00, r1, 16); xfer(16'h1200, r2, 16);
        cs_high();
        chk("R10 dropped writes", n_wr, wr0);
        chk("R10 no strobe at all", n_wr + n_rd + n_pop + n_push, all0);
        chk("R10 revid unchanged", int'(r1[7:0]), 'hA5);
        chk("R10 level unchanged", int'(r2[7:0]), 0);
    endtask

    task automatic t_abort();
        logic [15:0] r;
        int wr0 = n_wr, p0;
        cs_low(); xfer(16'h8899, r, 10); cs_high();
        chk("R12 aborted write no strobe", n_wr, wr0);
        chk("R12 aborted write no change", int'(regs[8]), 0);
        load_rx(8'h66);
        p0 = n_pop;
        cs_low(); xfer(16'h0000, r, 12); cs_high();
        chk("R12 aborted read no pop", n_pop, p0);
        cs_low(); xfer(16'h8899, r, 16); xfer(16'h1200, r, 16); cs_high();
        chk("R12 aligned write", int'(regs[8]), 'h99);
        chk("R12 level kept", int'(r[7:0]), 1);
        cs_low(); xfer(16'h0000, r, 16); cs_high();
        chk("R12 queued byte intact", int'(r[7:0]), 'h66);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_revid();
        t_wr_rd();
        t_b2b();
        t_push();
        t_pop();
        t_empty();
        t_ro();
        t_abort();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule